// File: doc/BRIEF.md
# Completion Event Ring Writer

This block sits behind a transfer engine and turns each finished-transfer report into a 16-byte record written into a circular ring in system memory. Software programs where the ring lives and how many bytes long it is. The block then places records one after another, moving its own write offset forward by 16 each time. The write offset is visible to software, so the consumer can see how far the producer has gone. Software returns space by posting the offset it has read up to on a doorbell register.

Every record carries a 4-bit completion code and a 4-bit error-info field in the top byte of its first word. If the report's descriptor asked for it, an end-of-block event pulse goes out together with the record. When the ring has no free slot, the block holds its completion input with `cpl_ready` low until software frees space. A doorbell value that could not be a valid read offset is dropped, and it sets a sticky error flag.

Top module: `event_ring_writer`

## Requirements
- R1: After reset, `cpl_ready` is 0, no record is written, `db_err` is 0, and the write offset (0x020) and read offset (0x400) both read 0.
- R2: The ring base is written as a low word at 0x008 and a high word at 0x00C, and the ring length in bytes is written at 0x010; all three read back. A write to 0x010 also returns the write and read offsets to 0.
- R3: Each record is a single 128-bit write to base plus the current write offset. Its first word sits in `mem_wdata[31:0]`, with the completion code in bits 31:28 and the error info in bits 27:24. Every other bit is 0.
- R4: A record appears on the memory port in the cycle after its completion is accepted (`cpl_valid` and `cpl_ready` both high at a clock edge). At that same edge the write offset read at 0x020 grows by 16.
- R5: If adding 16 to the write offset gives a value equal to or larger than the ring length, the write offset wraps to 0.
- R6: `eob_evt` pulses together with a record only when bit 16 of that report's `cpl_desc_cfg` is 1. It pulses at no other time.
- R7: `cpl_ready` is 0 when the next write offset (after wrap) would equal the read offset. While it is 0, no record is written.
- R8: A doorbell write to 0x400 sets the read offset, which reads back at 0x400. A value equal to the ring length is stored as 0. The space it frees shows on `cpl_ready` in the next cycle.
- R9: A doorbell value that is not a multiple of 16, or that is larger than the ring length, leaves the read offset unchanged. It sets `db_err`, which stays 1 until reset.
- R10: Records are written in the same order in which their completions were accepted.
- R11: A doorbell write and an accepted completion in the same cycle both take effect. The record uses the old write offset, and the new read offset governs `cpl_ready` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cpl_valid | input | 1 | Completion report valid |
| cpl_ready | output | 1 | Ring has a free slot; report is accepted |
| cpl_code | input | 4 | Completion code (1 done, 4 error) |
| cpl_info | input | 4 | Error info |
| cpl_desc_cfg | input | 32 | Descriptor configuration word; bit 16 requests end-of-block event |
| mem_we | output | 1 | Record write strobe |
| mem_addr | output | 64 | Record byte address |
| mem_wdata | output | 128 | Record contents |
| eob_evt | output | 1 | End-of-block event pulse |
| db_err | output | 1 | Sticky bad-doorbell flag |

## Verification
The two functions that can land in the same cycle are the acceptance of a completion and a doorbell write. The bench drives both in the same cycle while the write offset is 16 and the read offset is 48. It then checks that the record lands at offset 16, that the write offset moves to 32, and that the read offset becomes 48 so that `cpl_ready` drops because the ring is now full. A scoreboard of expected records, filled by the driver and drained by a monitor, also shows that no record appears while the ring is full.

// File: rtl/erw_pkg.sv
package erw_pkg;
   localparam int unsigned REC_BYTES = 16;
   localparam int unsigned REC_BITS  = REC_BYTES * 8;
   localparam int unsigned IEOB_BIT  = 16;

   localparam logic [11:0] RA_BASE_LO = 12'h008;
   localparam logic [11:0] RA_BASE_HI = 12'h00C;
   localparam logic [11:0] RA_LENGTH  = 12'h010;
   localparam logic [11:0] RA_WR_OFF  = 12'h020;
   localparam logic [11:0] RA_DOORBEL = 12'h400;

   typedef struct packed {
      logic [3:0] code;
      logic [3:0] info;
      logic       ieob;
   } cpl_t;

   function automatic logic [REC_BITS-1:0] pack_record(input logic [3:0] code,
                                                       input logic [3:0] info);
      logic [REC_BITS-1:0] r;
      r = '0;
      r[31:28] = code;
      r[27:24] = info;
      return r;
   endfunction
endpackage

// File: rtl/erw_regs.sv
module erw_regs #(
   parameter int unsigned OFF_W = 16,
   parameter int unsigned AW    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [11:0]      addr,
   input  logic [31:0]      wdata,
   input  logic [OFF_W-1:0] wr_off,
   output logic [AW-1:0]    base,
   output logic [OFF_W-1:0] len,
   output logic [OFF_W-1:0] rd_off,
   output logic             len_wr,
   output logic             db_err,
   output logic [31:0]      rdata
);
   import erw_pkg::*;

   logic db_hit, db_ok;

   assign len_wr = wr_en && (addr == RA_LENGTH);
   assign db_hit = wr_en && (addr == RA_DOORBEL);
   assign db_ok  = (wdata[3:0] == 4'd0) && (wdata <= 32'(len));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base   <= '0;
         len    <= '0;
         rd_off <= '0;
         db_err <= 1'b0;
      end else begin
         if (wr_en && addr == RA_BASE_LO) base[31:0] <= wdata;
         if (wr_en && addr == RA_BASE_HI) base[AW-1:32] <= wdata[AW-33:0];
         if (len_wr) begin
            len    <= wdata[OFF_W-1:0];
            rd_off <= '0;
         end else if (db_hit) begin
            if (db_ok)
               rd_off <= (wdata[OFF_W-1:0] == len) ? '0 : wdata[OFF_W-1:0];
            else
               db_err <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (addr)
         RA_BASE_LO: rdata = base[31:0];
         RA_BASE_HI: rdata = 32'(base[AW-1:32]);
         RA_LENGTH:  rdata = 32'(len);
         RA_WR_OFF:  rdata = 32'(wr_off);
         RA_DOORBEL: rdata = 32'(rd_off);
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/erw_wptr.sv
module erw_wptr #(
   parameter int unsigned OFF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OFF_W-1:0] len,
   input  logic [OFF_W-1:0] rd_off,
   input  logic             clear,
   input  logic             adv,
   output logic [OFF_W-1:0] wr_off,
   output logic             full
);
   import erw_pkg::*;

   logic [OFF_W:0]   sum;
   logic [OFF_W-1:0] nxt;

   assign sum  = {1'b0, wr_off} + (OFF_W+1)'(REC_BYTES);
   assign nxt  = (sum >= {1'b0, len}) ? '0 : sum[OFF_W-1:0];
   assign full = (nxt == rd_off);

   always_ff @(posedge clk) begin
      if (!rst_n)     wr_off <= '0;
      else if (clear) wr_off <= '0;
      else if (adv)   wr_off <= nxt;
   end
endmodule

// File: rtl/erw_emit.sv
module erw_emit #(
   parameter int unsigned AW      = 64,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fire,
   input  logic [AW-1:0]                addr_in,
   input  erw_pkg::cpl_t                cpl,
   output logic                         mem_we,
   output logic [AW-1:0]                mem_addr,
   output logic [erw_pkg::REC_BITS-1:0] mem_wdata,
   output logic                         eob_evt
);
   import erw_pkg::*;

   logic [REC_BITS-1:0] rec;
   assign rec = pack_record(cpl.code, cpl.info);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_we    <= 1'b0;
               mem_addr  <= '0;
               mem_wdata <= '0;
               eob_evt   <= 1'b0;
            end else begin
               mem_we  <= fire;
               eob_evt <= fire && cpl.ieob;
               if (fire) begin
                  mem_addr  <= addr_in;
                  mem_wdata <= rec;
               end
            end
         end
      end else begin : g_comb
         assign mem_we    = fire;
         assign eob_evt   = fire && cpl.ieob;
         assign mem_addr  = addr_in;
         assign mem_wdata = rec;
      end
   endgenerate
endmodule

// File: rtl/event_ring_writer.sv
module event_ring_writer #(
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned AW      = 64,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_wr_en,
   input  logic [11:0]  reg_addr,
   input  logic [31:0]  reg_wdata,
   output logic [31:0]  reg_rdata,
   input  logic         cpl_valid,
   output logic         cpl_ready,
   input  logic [3:0]   cpl_code,
   input  logic [3:0]   cpl_info,
   input  logic [31:0]  cpl_desc_cfg,
   output logic         mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [127:0] mem_wdata,
   output logic         eob_evt,
   output logic         db_err
);
   import erw_pkg::*;

   generate
      if (OFF_W < 5 || OFF_W > 32) begin : g_bad_off
         $error("OFF_W must lie in 5..32");
      end
      if (AW <= 32 || AW > 64) begin : g_bad_aw
         $error("AW must lie in 33..64");
      end
   endgenerate

   logic [AW-1:0]    base_q;
   logic [OFF_W-1:0] len_q, rd_off_q, wr_off_q;
   logic             len_wr, full, hs;
   cpl_t             cpl;

   assign cpl_ready = !full;
   assign hs        = cpl_valid && cpl_ready;
   assign cpl       = '{code: cpl_code, info: cpl_info, ieob: cpl_desc_cfg[IEOB_BIT]};

   erw_regs #(.OFF_W(OFF_W), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
      .wdata(reg_wdata), .wr_off(wr_off_q), .base(base_q), .len(len_q),
      .rd_off(rd_off_q), .len_wr(len_wr), .db_err(db_err), .rdata(reg_rdata)
   );

   erw_wptr #(.OFF_W(OFF_W)) u_wptr (
      .clk(clk), .rst_n(rst_n), .len(len_q), .rd_off(rd_off_q),
      .clear(len_wr), .adv(hs), .wr_off(wr_off_q), .full(full)
   );

   erw_emit #(.AW(AW), .OUT_REG(OUT_REG)) u_emit (
      .clk(clk), .rst_n(rst_n), .fire(hs),
      .addr_in(base_q + AW'(wr_off_q)), .cpl(cpl),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .eob_evt(eob_evt)
   );
endmodule

// File: rtl/erw_checker.sv
module erw_checker #(
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned AW      = 64,
   parameter bit          OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpl_valid,
   input logic             cpl_ready,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic             eob_evt,
   input logic             db_err,
   input logic             len_wr,
   input logic [AW-1:0]    base_q,
   input logic [OFF_W-1:0] len_q,
   input logic [OFF_W-1:0] wr_off_q
);
   // R6: event only accompanies a record
   a_r6_eob_with_record: assert property (@(posedge clk) disable iff (!rst_n)
      eob_evt |-> mem_we);

   // R9: bad-doorbell flag is sticky
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      db_err |=> db_err);

   // R4, R5: offset steps by one record or wraps to zero
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_ready && !len_wr) |=>
         (wr_off_q == $past(wr_off_q) + OFF_W'(16) || wr_off_q == '0));

   // R3: record lands inside the programmed ring
   a_r3_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ((mem_addr - base_q) < AW'(len_q)));

   generate
      if (OUT_REG) begin : g_seq
         // R4: accepted report yields a record one cycle later
         a_r4_record_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_valid && cpl_ready) |=> mem_we);
         // R7: a stalled report produces no record
         a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            !(cpl_valid && cpl_ready) |=> !mem_we);
      end else begin : g_cmb
         a_r4_record_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_valid && cpl_ready) |-> mem_we);
         a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            !cpl_ready |-> !mem_we);
      end
   endgenerate
endmodule

bind event_ring_writer erw_checker #(.OFF_W(OFF_W), .AW(AW), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
   .mem_we(mem_we), .mem_addr(mem_addr), .eob_evt(eob_evt), .db_err(db_err),
   .len_wr(len_wr), .base_q(base_q), .len_q(len_q), .wr_off_q(wr_off_q)
);

// File: tb/event_ring_writer_bench.sv
module event_ring_writer_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr_en = 1'b0;
   logic [11:0]  reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         cpl_valid = 1'b0;
   logic         cpl_ready;
   logic [3:0]   cpl_code = '0;
   logic [3:0]   cpl_info = '0;
   logic [31:0]  cpl_desc_cfg = '0;
   logic         mem_we;
   logic [63:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic         eob_evt;
   logic         db_err;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [63:0]  addr;
      logic [127:0] data;
      logic         eob;
   } exp_t;
   exp_t sb[$];

   localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;
   int unsigned ring_len = 64;
   int unsigned mwr = 0;

   always #5 clk = ~clk;

   event_ring_writer u_event_ring_writer (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpl_valid(cpl_valid),
      .cpl_ready(cpl_ready), .cpl_code(cpl_code), .cpl_info(cpl_info),
      .cpl_desc_cfg(cpl_desc_cfg), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .eob_evt(eob_evt), .db_err(db_err)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: R3, R4, R6, R10
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R7 unexpected record", mem_addr, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(mem_addr == e.addr, "R10 record address", mem_addr, e.addr);
            chk(mem_wdata == e.data, "R3 record contents", mem_wdata, e.data);
            chk(eob_evt == e.eob, "R6 end-of-block event", eob_evt, e.eob);
         end
      end else if (rst_n && eob_evt) begin
         chk(1'b0, "R6 event without record", eob_evt, 0);
      end
   end

   function automatic void expect_rec(input logic [3:0] c, input logic [3:0] i,
                                      input bit ieob);
      exp_t e;
      e.addr = BASE + 64'(mwr);
      e.data = {96'd0, c, i, 24'd0};
      e.eob  = ieob;
      sb.push_back(e);
      mwr = (mwr + 16 >= ring_len) ? 0 : mwr + 16;
   endfunction

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic drive_cpl(input logic [3:0] c, input logic [3:0] i, input bit ieob);
      cpl_valid = 1'b1; cpl_code = c; cpl_info = i;
      cpl_desc_cfg = 32'h0000_0A05 | (32'(ieob) << 16);
   endtask

   task automatic send(input logic [3:0] c, input logic [3:0] i, input bit ieob);
      expect_rec(c, i, ieob);
      @(negedge clk);
      drive_cpl(c, i, ieob);
      while (!cpl_ready) @(negedge clk);
      @(negedge clk);
      cpl_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      fork
         begin
            repeat (3) @(negedge clk);
            // R1 reset state
            chk(cpl_ready == 1'b0, "R1 ready low", cpl_ready, 0);
            chk(mem_we == 1'b0, "R1 no write", mem_we, 0);
            chk(db_err == 1'b0, "R1 db_err clear", db_err, 0);
            reg_rd(12'h020, v); chk(v == 0, "R1 write offset", v, 0);
            reg_rd(12'h400, v); chk(v == 0, "R1 read offset", v, 0);
            rst_n = 1'b1;

            // R2 programming and readback
            reg_wr(12'h008, BASE[31:0]);
            reg_wr(12'h00C, BASE[63:32]);
            reg_wr(12'h010, 32'd64);
            reg_rd(12'h008, v); chk(v == BASE[31:0], "R2 base low", v, BASE[31:0]);
            reg_rd(12'h00C, v); chk(v == BASE[63:32], "R2 base high", v, BASE[63:32]);
            reg_rd(12'h010, v); chk(v == 64, "R2 length", v, 64);

            // R3 R4 R6 three records
            send(4'd1, 4'd0, 1'b1);
            send(4'd4, 4'hF, 1'b0);
            send(4'd1, 4'd2, 1'b1);
            reg_rd(12'h020, v); chk(v == 48, "R4 write offset", v, 48);

            // R7 full: held report must not be written
            chk(cpl_ready == 1'b0, "R7 ready low when full", cpl_ready, 0);
            @(negedge clk); drive_cpl(4'd1, 4'd3, 1'b1);
            repeat (4) @(negedge clk);
            chk(cpl_ready == 1'b0, "R7 still stalled", cpl_ready, 0);
            cpl_valid = 1'b0;

            // R9 bad doorbells ignored
            reg_wr(12'h400, 32'd8);
            chk(db_err == 1'b1, "R9 misaligned sets flag", db_err, 1);
            reg_wr(12'h400, 32'd80);
            reg_rd(12'h400, v); chk(v == 0, "R9 read offset unchanged", v, 0);
            chk(cpl_ready == 1'b0, "R9 no space freed", cpl_ready, 0);

            // R8 doorbell frees space
            reg_wr(12'h400, 32'd32);
            reg_rd(12'h400, v); chk(v == 32, "R8 read offset", v, 32);
            chk(cpl_ready == 1'b1, "R8 ready after doorbell", cpl_ready, 1);

            // R5 wrap
            send(4'd1, 4'd5, 1'b0);
            reg_rd(12'h020, v); chk(v == 0, "R5 wrap to zero", v, 0);
            send(4'd4, 4'd6, 1'b1);
            chk(cpl_ready == 1'b0, "R7 full after wrap", cpl_ready, 0);

            // R11 doorbell and completion in the same cycle
            reg_wr(12'h400, 32'd48);
            expect_rec(4'd1, 4'd7, 1'b1);
            @(negedge clk);
            drive_cpl(4'd1, 4'd7, 1'b1);
            reg_wr_en = 1'b1; reg_addr = 12'h400; reg_wdata = 32'd48;
            chk(cpl_ready == 1'b1, "R11 ready before", cpl_ready, 1);
            @(negedge clk);
            cpl_valid = 1'b0; reg_wr_en = 1'b0;
            chk(cpl_ready == 1'b0, "R11 full after both", cpl_ready, 0);
            reg_rd(12'h020, v); chk(v == 32, "R11 write offset", v, 32);
            reg_rd(12'h400, v); chk(v == 48, "R11 read offset", v, 48);

            // R8 doorbell equal to length stored as zero
            reg_wr(12'h400, 32'd64);
            reg_rd(12'h400, v); chk(v == 0, "R8 length maps to zero", v, 0);

            // R2 length rewrite resets offsets
            reg_wr(12'h010, 32'd128);
            ring_len = 128; mwr = 0;
            reg_rd(12'h020, v); chk(v == 0, "R2 write offset cleared", v, 0);
            send(4'd4, 4'd9, 1'b0);
            reg_rd(12'h020, v); chk(v == 16, "R4 after resize", v, 16);
            chk(db_err == 1'b1, "R9 flag sticky", db_err, 1);

            repeat (3) @(negedge clk);
            chk(sb.size() == 0, "R10 all records seen", sb.size(), 0);

            // R9 flag cleared by reset
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            chk(db_err == 1'b0, "R9 reset clears flag", db_err, 0);
            chk(cpl_ready == 1'b0, "R1 ready low after reset", cpl_ready, 0);
         end
         begin
            repeat (20000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule